// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the two independent ports of a shared RAM and detects the moment both ports, while enabled, point at the same address. When that happens it decides which port keeps the location and signals the other port with an active-low busy flag. The losing port's write strobe is then held off before it reaches the array. Reads and writes are treated alike: only the enables and addresses take part in the decision. The port that settled on the address first wins. If both ports arrive in the same clock cycle, the left port wins.

A mode input chooses between two kinds of operation. In master mode the block makes the busy decision itself. In slave mode it makes no decision: the busy outputs stay high, and externally supplied busy inputs only block the matching port's writes. Several RAM slices can therefore share the decision of one master. Inputs are sampled on the rising clock edge. Each busy output is a register, so a collision shows on the busy flags one cycle after it is sampled. The write-enable outputs to the array are gated combinationally in the same cycle as the busy flag that governs them.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: When either port is disabled or the two addresses differ, both busy outputs are high (inactive) one clock cycle later.
- R2: When one port is already enabled on an address and the other port moves onto that same address later, the later port's busy output goes low one cycle later and the earlier port's busy stays high.
- R3: When both ports begin matching in the same cycle, the right port's busy output goes low and the left port's stays high.
- R4: The two busy outputs are never low at the same time.
- R5: The arbitration outcome does not depend on either port's write strobe. A read-only holder and a writing holder both keep the location against a later arrival.
- R6: In master mode a port's write-enable output equals enable AND write strobe AND that port's registered busy output. A port whose busy is low produces no write to the array.
- R7: In slave mode (mode input high) both busy outputs are held high, and a low external busy input forces the matching port's write-enable output low. A high external busy input lets the write through.
- R8: When the addresses stop matching or an enable falls, the busy flag returns high one cycle later.
- R9: While a match lasts, the busy decision does not change, even when either port toggles its write strobe.
- R10: After reset both busy outputs are high. A new collision first appears on the busy outputs one cycle after the inputs that cause it are sampled, and during that first cycle the write-enable outputs still pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1: slave operation, 0: master operation |
| left_en | input | 1 | Left port enable, active high |
| left_we | input | 1 | Left port write strobe, active high |
| left_addr | input | ADDR_W | Left port address |
| right_en | input | 1 | Right port enable, active high |
| right_we | input | 1 | Right port write strobe, active high |
| right_addr | input | ADDR_W | Right port address |
| busy_left_in_n | input | 1 | External busy for the left port (slave mode), active low |
| busy_right_in_n | input | 1 | External busy for the right port (slave mode), active low |
| busy_left_n | output | 1 | Left port busy flag, active low, registered |
| busy_right_n | output | 1 | Right port busy flag, active low, registered |
| left_we_gated | output | 1 | Left write enable to the array after gating |
| right_we_gated | output | 1 | Right write enable to the array after gating |

## Verification
The arbitration is tried with four kinds of arrival: a right-first arrival, a left-first arrival, both ports arriving together, and a near miss where the addresses differ or one port is disabled. These separate a design that truly orders arrivals from one that always favours one side or flags any shared address. The same arrival pattern is repeated with the holder reading and then writing, which exposes any dependence on the write strobe. Toggling write strobes during a held match shows whether the grant persists. A release followed by a fresh collision shows whether state is cleared. Slave mode is driven with each external busy input low in turn, which shows that writes are inhibited per port and that no internal decision leaks onto the busy outputs.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef struct packed {
        logic left_n;
        logic right_n;
    } busy_pair_t;

    localparam busy_pair_t BUSY_NONE       = '{left_n: 1'b1, right_n: 1'b1};
    localparam busy_pair_t BUSY_LEFT_LOSES  = '{left_n: 1'b0, right_n: 1'b1};
    localparam busy_pair_t BUSY_RIGHT_LOSES = '{left_n: 1'b1, right_n: 1'b0};

endpackage

// File: rtl/dpa_port_track.sv
// Remembers one port's last enable/address and flags a fresh request:
// enabled now, and either newly enabled or on a different address.
module dpa_port_track #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en   = en;
        st_d.addr = addr;
        fresh     = en && (!st_q.en || (addr != st_q.addr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dpa_write_gate.sv
// Passes a port's write strobe only when the busy that governs it is high.
module dpa_write_gate (
    input  logic slave_mode,
    input  logic en,
    input  logic we,
    input  logic busy_int_n,
    input  logic busy_ext_n,
    output logic we_out
);
    logic allow;

    always_comb begin
        allow  = slave_mode ? busy_ext_n : busy_int_n;
        we_out = en && we && allow;
    end
endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              left_en,
    input  logic              left_we,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              right_en,
    input  logic              right_we,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic              busy_left_in_n,
    input  logic              busy_right_in_n,
    output logic              busy_left_n,
    output logic              busy_right_n,
    output logic              left_we_gated,
    output logic              right_we_gated
);
    localparam int NPORT = 2;

    typedef struct packed {
        busy_pair_t busy;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NPORT-1:0]        en_v, we_v, fresh_v, ext_v, int_v, gated_v;
    logic [ADDR_W-1:0]       addr_v [NPORT];
    logic                    match;
    logic                    held;

    assign en_v      = {right_en, left_en};
    assign we_v      = {right_we, left_we};
    assign addr_v[0] = left_addr;
    assign addr_v[1] = right_addr;
    assign ext_v     = {busy_right_in_n, busy_left_in_n};
    assign int_v     = {st_q.busy.right_n, st_q.busy.left_n};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .fresh (fresh_v[p])
        );
        dpa_write_gate u_gate (
            .slave_mode (slave_mode),
            .en         (en_v[p]),
            .we         (we_v[p]),
            .busy_int_n (int_v[p]),
            .busy_ext_n (ext_v[p]),
            .we_out     (gated_v[p])
        );
    end

    always_comb begin
        st_d  = st_q;
        match = left_en && right_en && (left_addr == right_addr);
        held  = !st_q.busy.left_n || !st_q.busy.right_n;
        if (slave_mode || !match) begin
            st_d.busy = BUSY_NONE;
        end else if (!held || (fresh_v[0] && fresh_v[1])) begin
            // Later arrival loses; a same-cycle arrival goes to the left port.
            if (fresh_v[0] && !fresh_v[1]) st_d.busy = BUSY_LEFT_LOSES;
            else                           st_d.busy = BUSY_RIGHT_LOSES;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: BUSY_NONE};
        else        st_q <= st_d;
    end

    assign busy_left_n    = st_q.busy.left_n;
    assign busy_right_n   = st_q.busy.right_n;
    assign left_we_gated  = gated_v[0];
    assign right_we_gated = gated_v[1];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              left_en,
    input logic              left_we,
    input logic [ADDR_W-1:0] left_addr,
    input logic              right_en,
    input logic              right_we,
    input logic [ADDR_W-1:0] right_addr,
    input logic              busy_left_in_n,
    input logic              busy_right_in_n,
    input logic              busy_left_n,
    input logic              busy_right_n,
    input logic              left_we_gated,
    input logic              right_we_gated
);
    logic same;
    assign same = left_en && right_en && (left_addr == right_addr);

    // R1 and R8: no collision means both flags idle next cycle
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !same |=> (busy_left_n && busy_right_n));

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy_left_n && !busy_right_n));

    a_r6_block_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !busy_left_n) |-> !left_we_gated);

    a_r6_block_right: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !busy_right_n) |-> !right_we_gated);

    a_r7_slave_idle: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |=> (busy_left_n && busy_right_n));

    a_r7_slave_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && (!busy_left_in_n || !busy_right_in_n)) |->
        (!(left_we_gated && !busy_left_in_n) && !(right_we_gated && !busy_right_in_n)));

    a_r9_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && same && !busy_left_n) |=> !busy_left_n);

    a_r9_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && same && !busy_right_n) |=> !busy_right_n);
endmodule

bind dpa_collision_arbiter dpa_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpa_collision_arbiter_tb.sv
`timescale 1ns/1ps
module dpa_collision_arbiter_tb;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          left_en = 1'b0, left_we = 1'b0;
    logic [AW-1:0] left_addr = '0;
    logic          right_en = 1'b0, right_we = 1'b0;
    logic [AW-1:0] right_addr = '0;
    logic          busy_left_in_n = 1'b1, busy_right_in_n = 1'b1;
    logic          busy_left_n, busy_right_n, left_we_gated, right_we_gated;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dpa_collision_arbiter #(.ADDR_W(AW)) u_dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Settle just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
        check("R4 never both low", {31'd0, busy_left_n | busy_right_n}, 32'd1);
    endtask

    task automatic drive(input logic le, input logic lw, input logic [AW-1:0] la,
                         input logic re, input logic rw, input logic [AW-1:0] ra);
        @(negedge clk);
        left_en = le; left_we = lw; left_addr = la;
        right_en = re; right_we = rw; right_addr = ra;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
        tick();
    endtask

    task automatic t_reset();
        check("R10 reset busy_left_n", busy_left_n, 1);
        check("R10 reset busy_right_n", busy_right_n, 1);
    endtask

    task automatic t_no_match();
        drive(1'b1, 1'b1, 11'h010, 1'b1, 1'b1, 11'h011); tick();
        check("R1 diff addr left", busy_left_n, 1);
        check("R1 diff addr right", busy_right_n, 1);
        check("R6 pass left", left_we_gated, 1);
        drive(1'b1, 1'b1, 11'h020, 1'b0, 1'b1, 11'h020); tick();
        check("R1 right disabled left", busy_left_n, 1);
        check("R1 right disabled right", busy_right_n, 1);
        idle();
    endtask

    task automatic t_later_left();
        drive(1'b0, 1'b0, '0, 1'b1, 1'b0, 11'h123); tick();
        drive(1'b1, 1'b1, 11'h123, 1'b1, 1'b0, 11'h123);
        #1;
        check("R10 busy not yet low", busy_left_n, 1);
        check("R10 first cycle write passes", left_we_gated, 1);
        tick();
        check("R2 later left loses", busy_left_n, 0);
        check("R2 earlier right keeps", busy_right_n, 1);
        check("R6 left write blocked", left_we_gated, 0);
        drive(1'b1, 1'b1, 11'h123, 1'b1, 1'b1, 11'h123); tick();
        check("R6 right write passes", right_we_gated, 1);
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, i[0], 11'h123, 1'b1, ~i[0], 11'h123); tick();
            check("R9 hold left low", busy_left_n, 0);
            check("R9 hold right high", busy_right_n, 1);
        end
        drive(1'b1, 1'b1, 11'h124, 1'b1, 1'b1, 11'h123); tick();
        check("R8 release on addr change", {busy_left_n, busy_right_n}, 2'b11);
        check("R8 left write passes again", left_we_gated, 1);
        drive(1'b1, 1'b1, 11'h123, 1'b1, 1'b1, 11'h123); tick();
        check("R2 left re-arrives loses", busy_left_n, 0);
        drive(1'b1, 1'b1, 11'h123, 1'b0, 1'b1, 11'h123); tick();
        check("R8 release on enable drop", {busy_left_n, busy_right_n}, 2'b11);
        idle();
    endtask

    task automatic t_later_right();
        drive(1'b1, 1'b0, 11'h7FF, 1'b0, 1'b0, '0); tick();
        drive(1'b1, 1'b0, 11'h7FF, 1'b1, 1'b1, 11'h7FF); tick();
        check("R5 read holder wins, right loses", {busy_left_n, busy_right_n}, 2'b10);
        check("R6 right write blocked", right_we_gated, 0);
        idle();
        drive(1'b1, 1'b1, 11'h7FF, 1'b0, 1'b0, '0); tick();
        drive(1'b1, 1'b1, 11'h7FF, 1'b1, 1'b0, 11'h7FF); tick();
        check("R5 write holder wins, right loses", {busy_left_n, busy_right_n}, 2'b10);
        check("R6 left holder write passes", left_we_gated, 1);
        idle();
    endtask

    task automatic t_same_cycle();
        drive(1'b1, 1'b1, 11'h000, 1'b1, 1'b1, 11'h000); tick();
        check("R3 tie left keeps", busy_left_n, 1);
        check("R3 tie right loses", busy_right_n, 0);
        check("R3 tie right write blocked", right_we_gated, 0);
        idle();
    endtask

    task automatic t_slave();
        @(negedge clk) slave_mode = 1'b1;
        drive(1'b1, 1'b1, 11'h055, 1'b1, 1'b1, 11'h055); tick();
        check("R7 slave no decision", {busy_left_n, busy_right_n}, 2'b11);
        check("R7 both writes pass", {left_we_gated, right_we_gated}, 2'b11);
        @(negedge clk) busy_left_in_n = 1'b0;
        #1;
        check("R7 left inhibited", {left_we_gated, right_we_gated}, 2'b01);
        @(negedge clk) begin busy_left_in_n = 1'b1; busy_right_in_n = 1'b0; end
        #1;
        check("R7 right inhibited", {left_we_gated, right_we_gated}, 2'b10);
        @(negedge clk) begin busy_right_in_n = 1'b1; slave_mode = 1'b0; end
        idle();
    endtask

    initial begin
        #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_no_match();
        t_later_left();
        t_later_right();
        t_same_cycle();
        t_slave();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule